// File: doc/BRIEF.md
# Priority Deficit Round-Robin Arbiter

This block picks one of ten command requesters for each slot on a single downstream command port. Each slot carries one two-beat burst. Every requester has a programmable absolute priority and a static weight. A strictly higher priority always beats a lower one. Requesters that tie on priority share the slots by deficit round-robin: each keeps a running weight, the largest running weight wins, and the running weights move so that, over time, each requester's share follows its static weight.

Software writes a flat configuration image: priorities, weights, one sum of weights per priority level, and a promotion mask. The arbiter does not use this image directly. It copies the image into its active state once every ten clock cycles. Because of this, a configuration written partway through is never seen half-applied within one interval. The promotion mask lifts chosen priority levels ahead of every unpromoted requester.

A requester is eligible only when it has a pending transaction and can move a full burst. For a write, the burst data must be complete. For a read, the shared read-space flag must be set. A decision is made in every cycle in which the downstream side is ready. The grant appears one cycle later as a one-cycle, one-hot pulse.

Top module: `pdrr_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `gnt_valid` is 0 and `gnt_onehot` is all zeros. Every running weight starts at 0x80.
- R2: Port i is eligible only when `req_valid[i]` is 1 and one of these holds: `req_write[i]`=1 and `wr_burst_full[i]`=1, or `req_write[i]`=0 and `rd_space_ok`=1. A port that is not eligible is never granted.
- R3: Among the eligible ports, only those with the highest active priority (0 lowest, 7 highest) can be granted.
- R4: Among the candidates at the winning priority, the port with the largest 8-bit running weight is granted. On a tie, the lowest-numbered port wins.
- R5: In a decision cycle, the granted port's running weight becomes rw + static weight − sum of weights of its level, modulo 256. Every other candidate at that level gains its own static weight. Two ports at one level with weights 4 and 1 and a level sum of 5 receive 40 and 10 of 50 consecutive slots.
- R6: The running weight of a valid port whose priority differs from the winning level does not change in that cycle.
- R7: In any cycle where `req_valid[i]` is 0, port i's running weight is reloaded to 0x80. This takes priority over any other update.
- R8: The configuration image is copied into the active state on the 10th clock edge after reset is released, and on every 10th edge after that. A decision made on a commit edge still uses the previous active values.
- R9: If bit p of `cfg_remap_img` is set and an eligible port has priority p, then only such promoted ports are candidates. Among the promoted ports, R3 and R4 still apply.
- R10: A grant is a one-cycle pulse. `gnt_valid` is 1 and `gnt_onehot` has exactly bit i set, in the cycle after a decision cycle: `ds_ready` was 1 and at least one port was eligible. In all other cycles both outputs are 0.
- R11: Field positions are as follows. Port i's priority is `cfg_prio_img[3i+2:3i]`. Port i's weight is `cfg_weight_img[5i+4:5i]`. The sum for level p is `cfg_sum_img[8p+7:8p]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prio_img | input | 30 | Shadow priority image, 3 bits per port |
| cfg_weight_img | input | 50 | Shadow static weights, 5 bits per port |
| cfg_sum_img | input | 64 | Shadow sum of weights, 8 bits per level |
| cfg_remap_img | input | 8 | Shadow promotion mask, one bit per level |
| req_valid | input | 10 | Port has a pending transaction |
| req_write | input | 10 | Pending transaction is a write (1) or read (0) |
| wr_burst_full | input | 10 | Full burst of write data is present |
| rd_space_ok | input | 1 | Read buffer has room for a burst |
| ds_ready | input | 1 | Downstream accepts a decision this cycle |
| gnt_valid | output | 1 | Grant pulse |
| gnt_onehot | output | 10 | One-hot index of the granted port |

## Verification
Two functions can land on the same clock edge: the periodic commit and an arbitration decision with its running-weight update. When they do, the decision must use the configuration that was active before the commit. The bench provokes this by holding requests from two ports whose relative order flips under the new image, and keeping them held across the tenth edge after reset and across later commit edges. A scoreboard model then judges the result. The model computes each expected grant and running-weight step first, and only afterwards applies the commit that falls on the same edge. The reload of an emptied port can also coincide with a decision at its level. This case is judged the same way, with the reload taking precedence.

// File: rtl/pdrr_pkg.sv
`timescale 1ns/1ps
package pdrr_pkg;
  localparam int RW_W = 8;
  localparam logic [RW_W-1:0] RW_RELOAD = 8'h80;

  // running weight of the port that wins a slot
  function automatic logic [RW_W-1:0] rw_on_grant(input logic [RW_W-1:0] rw,
                                                  input logic [RW_W-1:0] sw,
                                                  input logic [RW_W-1:0] lvl_sum);
    return rw + sw - lvl_sum;
  endfunction

  // running weight of a same-level candidate that loses the slot
  function automatic logic [RW_W-1:0] rw_on_pass(input logic [RW_W-1:0] rw,
                                                 input logic [RW_W-1:0] sw);
    return rw + sw;
  endfunction
endpackage

// File: rtl/pdrr_cfg_commit.sv
`timescale 1ns/1ps
module pdrr_cfg_commit #(
  parameter int NPORT  = 10,
  parameter int PW     = 3,
  parameter int WW     = 5,
  parameter int SUMW   = 8,
  parameter int PERIOD = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPORT*PW-1:0]         shadow_prio,
  input  logic [NPORT*WW-1:0]         shadow_weight,
  input  logic [(1<<PW)*SUMW-1:0]     shadow_sum,
  input  logic [(1<<PW)-1:0]          shadow_remap,
  output logic [NPORT*PW-1:0]         act_prio,
  output logic [NPORT*WW-1:0]         act_weight,
  output logic [(1<<PW)*SUMW-1:0]     act_sum,
  output logic [(1<<PW)-1:0]          act_remap,
  output logic                        commit
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] tick_q;

  assign commit = (tick_q == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q     <= '0;
      act_prio   <= '0;
      act_weight <= '0;
      act_sum    <= '0;
      act_remap  <= '0;
    end else if (commit) begin
      tick_q     <= '0;
      act_prio   <= shadow_prio;
      act_weight <= shadow_weight;
      act_sum    <= shadow_sum;
      act_remap  <= shadow_remap;
    end else begin
      tick_q     <= tick_q + 1'b1;
    end
  end
endmodule

// File: rtl/pdrr_pick.sv
`timescale 1ns/1ps
module pdrr_pick #(
  parameter int NPORT = 10,
  parameter int PW    = 3
) (
  input  logic [NPORT-1:0]                  elig,
  input  logic [NPORT*PW-1:0]               act_prio,
  input  logic [(1<<PW)-1:0]                act_remap,
  input  logic [NPORT*pdrr_pkg::RW_W-1:0]   rw_flat,
  output logic [NPORT-1:0]                  cand,
  output logic [NPORT-1:0]                  win_onehot,
  output logic [PW-1:0]                     top_lvl,
  output logic                              any_elig
);
  import pdrr_pkg::*;

  logic [NPORT-1:0] promo;
  logic [NPORT-1:0] pool;
  logic [RW_W-1:0]  best;
  logic             found;

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      promo[i] = elig[i] & act_remap[act_prio[i*PW +: PW]];
    end
    pool = (|promo) ? promo : elig;

    top_lvl = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (pool[i] && (act_prio[i*PW +: PW] > top_lvl)) begin
        top_lvl = act_prio[i*PW +: PW];
      end
    end

    for (int i = 0; i < NPORT; i++) begin
      cand[i] = pool[i] && (act_prio[i*PW +: PW] == top_lvl);
    end

    best       = '0;
    found      = 1'b0;
    win_onehot = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (cand[i] && (!found || (rw_flat[i*RW_W +: RW_W] > best))) begin
        best       = rw_flat[i*RW_W +: RW_W];
        found      = 1'b1;
        win_onehot = '0;
        win_onehot[i] = 1'b1;
      end
    end

    any_elig = |elig;
  end
endmodule

// File: rtl/pdrr_rw_bank.sv
`timescale 1ns/1ps
module pdrr_rw_bank #(
  parameter int NPORT = 10,
  parameter int WW    = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NPORT-1:0]                  req_valid,
  input  logic                              step,
  input  logic [NPORT-1:0]                  cand,
  input  logic [NPORT-1:0]                  win_onehot,
  input  logic [NPORT*WW-1:0]               act_weight,
  input  logic [pdrr_pkg::RW_W-1:0]         lvl_sum,
  output logic [NPORT*pdrr_pkg::RW_W-1:0]   rw_flat
);
  import pdrr_pkg::*;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic [RW_W-1:0] rw_q;
    logic [RW_W-1:0] sw;

    assign sw = RW_W'(act_weight[g*WW +: WW]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rw_q <= RW_RELOAD;
      end else if (!req_valid[g]) begin
        rw_q <= RW_RELOAD;
      end else if (step && win_onehot[g]) begin
        rw_q <= rw_on_grant(rw_q, sw, lvl_sum);
      end else if (step && cand[g]) begin
        rw_q <= rw_on_pass(rw_q, sw);
      end
    end

    assign rw_flat[g*RW_W +: RW_W] = rw_q;
  end
endmodule

// File: rtl/pdrr_arbiter.sv
`timescale 1ns/1ps
module pdrr_arbiter #(
  parameter int NPORT         = 10,
  parameter int PRIO_W        = 3,
  parameter int WEIGHT_W      = 5,
  parameter int SUM_W         = 8,
  parameter int COMMIT_PERIOD = 10
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NPORT*PRIO_W-1:0]           cfg_prio_img,
  input  logic [NPORT*WEIGHT_W-1:0]         cfg_weight_img,
  input  logic [(1<<PRIO_W)*SUM_W-1:0]      cfg_sum_img,
  input  logic [(1<<PRIO_W)-1:0]            cfg_remap_img,
  input  logic [NPORT-1:0]                  req_valid,
  input  logic [NPORT-1:0]                  req_write,
  input  logic [NPORT-1:0]                  wr_burst_full,
  input  logic                              rd_space_ok,
  input  logic                              ds_ready,
  output logic                              gnt_valid,
  output logic [NPORT-1:0]                  gnt_onehot
);
  import pdrr_pkg::*;

  localparam int NLVL = 1 << PRIO_W;

  logic [NPORT*PRIO_W-1:0]   act_prio_w;
  logic [NPORT*WEIGHT_W-1:0] act_weight_w;
  logic [NLVL*SUM_W-1:0]     act_sum_w;
  logic [NLVL-1:0]           act_remap_w;
  logic                      commit_w;
  logic [NPORT-1:0]          elig_w;
  logic [NPORT-1:0]          cand_w;
  logic [NPORT-1:0]          win_w;
  logic [PRIO_W-1:0]         top_lvl_w;
  logic                      any_elig_w;
  logic                      step_w;
  logic [RW_W-1:0]           lvl_sum_w;
  logic [NPORT*RW_W-1:0]     rw_flat_w;

  // a port may compete only when it can move a whole burst
  assign elig_w = req_valid & ((req_write & wr_burst_full) |
                               (~req_write & {NPORT{rd_space_ok}}));
  assign step_w    = ds_ready & any_elig_w;
  assign lvl_sum_w = RW_W'(act_sum_w[top_lvl_w*SUM_W +: SUM_W]);

  pdrr_cfg_commit #(
    .NPORT(NPORT), .PW(PRIO_W), .WW(WEIGHT_W), .SUMW(SUM_W), .PERIOD(COMMIT_PERIOD)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .shadow_prio(cfg_prio_img), .shadow_weight(cfg_weight_img),
    .shadow_sum(cfg_sum_img), .shadow_remap(cfg_remap_img),
    .act_prio(act_prio_w), .act_weight(act_weight_w),
    .act_sum(act_sum_w), .act_remap(act_remap_w),
    .commit(commit_w)
  );

  pdrr_pick #(.NPORT(NPORT), .PW(PRIO_W)) u_pick (
    .elig(elig_w), .act_prio(act_prio_w), .act_remap(act_remap_w),
    .rw_flat(rw_flat_w), .cand(cand_w), .win_onehot(win_w),
    .top_lvl(top_lvl_w), .any_elig(any_elig_w)
  );

  pdrr_rw_bank #(.NPORT(NPORT), .WW(WEIGHT_W)) u_rw (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .step(step_w),
    .cand(cand_w), .win_onehot(win_w), .act_weight(act_weight_w),
    .lvl_sum(lvl_sum_w), .rw_flat(rw_flat_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid  <= 1'b0;
      gnt_onehot <= '0;
    end else begin
      gnt_valid  <= step_w;
      gnt_onehot <= step_w ? win_w : '0;
    end
  end
endmodule

// File: rtl/pdrr_checker.sv
`timescale 1ns/1ps
module pdrr_checker #(
  parameter int NPORT = 10,
  parameter int PW    = 3,
  parameter int WW    = 5
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              ds_ready,
  input logic [NPORT-1:0]                  req_valid,
  input logic [NPORT-1:0]                  elig,
  input logic                              any_elig,
  input logic                              commit,
  input logic [NPORT*PW-1:0]               act_prio,
  input logic [NPORT*WW-1:0]               act_weight,
  input logic [PW-1:0]                     top_lvl,
  input logic [NPORT*pdrr_pkg::RW_W-1:0]   rw_flat,
  input logic                              gnt_valid,
  input logic [NPORT-1:0]                  gnt_onehot
);
  import pdrr_pkg::*;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_onehot) && (gnt_valid == (gnt_onehot != '0))) else $error("grant shape"); // R10

  AST_GNT_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> $past(ds_ready)) else $error("grant without ready"); // R10

  AST_IDLE_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_ready |=> !gnt_valid) else $error("grant while stalled"); // R10

  AST_GNT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (($past(elig) & gnt_onehot) != '0)) else $error("ineligible grant"); // R2

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(act_prio) && $stable(act_weight))) else $error("config moved off-commit"); // R8

  for (genvar g = 0; g < NPORT; g++) begin : g_chk
    AST_DRAIN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid[g] |=> (rw_flat[g*RW_W +: RW_W] == RW_RELOAD)) else $error("no reload"); // R7

    AST_OTHER_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ds_ready && any_elig && req_valid[g] && (act_prio[g*PW +: PW] != top_lvl))
      |=> $stable(rw_flat[g*RW_W +: RW_W])) else $error("other level touched"); // R6
  end
endmodule

bind pdrr_arbiter pdrr_checker #(.NPORT(NPORT), .PW(PRIO_W), .WW(WEIGHT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ds_ready(ds_ready), .req_valid(req_valid),
  .elig(elig_w), .any_elig(any_elig_w), .commit(commit_w),
  .act_prio(act_prio_w), .act_weight(act_weight_w), .top_lvl(top_lvl_w),
  .rw_flat(rw_flat_w), .gnt_valid(gnt_valid), .gnt_onehot(gnt_onehot)
);

// File: tb/sim_pdrr_arbiter.sv
`timescale 1ns/1ps
module sim_pdrr_arbiter;
  localparam int NP = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] cfg_prio;
  logic [49:0] cfg_w;
  logic [63:0] cfg_sum;
  logic [7:0]  cfg_remap;
  logic [9:0]  req_valid, req_write, wr_full;
  logic        rd_ok, ds_ready;
  logic        gnt_valid;
  logic [9:0]  gnt_onehot;

  always #4 clk = ~clk;

  pdrr_arbiter u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_prio_img(cfg_prio), .cfg_weight_img(cfg_w),
    .cfg_sum_img(cfg_sum), .cfg_remap_img(cfg_remap),
    .req_valid(req_valid), .req_write(req_write), .wr_burst_full(wr_full),
    .rd_space_ok(rd_ok), .ds_ready(ds_ready),
    .gnt_valid(gnt_valid), .gnt_onehot(gnt_onehot)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state, rebuilt from the requirements
  logic [7:0]  m_rw [NP];
  logic [29:0] m_prio;
  logic [49:0] m_w;
  logic [63:0] m_sum;
  logic [7:0]  m_remap;
  int          m_cnt;

  logic [9:0] exp_q[$];
  string      tag_q[$];
  int         gcount[NP];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected grant per clock edge
  initial forever begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) begin
      logic [9:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {21'b0, gnt_valid, gnt_onehot}, {21'b0, (e != 10'b0), e});
      for (int i = 0; i < NP; i++) if (gnt_onehot[i]) gcount[i]++;
    end
  end

  // driver: predicts this cycle, queues it, advances the model
  task automatic cyc(input string tag);
    logic [9:0]  el;
    logic [15:0] sc, best;
    logic [9:0]  e;
    logic [2:0]  wp;
    logic [7:0]  nrw [NP];
    int          wi;
    wi = -1;
    best = '0;
    for (int i = 0; i < NP; i++)
      el[i] = req_valid[i] && (req_write[i] ? wr_full[i] : rd_ok);
    for (int i = 0; i < NP; i++) begin
      if (el[i]) begin
        sc = {m_remap[m_prio[3*i +: 3]], m_prio[3*i +: 3], m_rw[i], 4'(15 - i)};
        if (wi < 0 || sc > best) begin
          best = sc;
          wi = i;
        end
      end
    end
    e = (ds_ready && wi >= 0) ? (10'b1 << wi) : 10'b0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    wp = best[14:12];
    for (int i = 0; i < NP; i++) begin
      nrw[i] = m_rw[i];
      if (!req_valid[i]) nrw[i] = 8'h80;
      else if (ds_ready && wi >= 0) begin
        if (i == wi)
          nrw[i] = m_rw[i] + 8'(m_w[5*i +: 5]) - m_sum[8*wp +: 8];
        else if (el[i] && m_prio[3*i +: 3] == wp)
          nrw[i] = m_rw[i] + 8'(m_w[5*i +: 5]);
      end
    end
    for (int i = 0; i < NP; i++) m_rw[i] = nrw[i];
    if (m_cnt == 9) begin
      m_cnt = 0;
      m_prio = cfg_prio; m_w = cfg_w; m_sum = cfg_sum; m_remap = cfg_remap;
    end else begin
      m_cnt++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [9:0] v, input logic [9:0] wr, input logic [9:0] full,
                       input logic rd, input logic rdy);
    req_valid = v; req_write = wr; wr_full = full; rd_ok = rd; ds_ready = rdy;
  endtask

  task automatic fill_sums();
    logic [7:0] s [8];
    for (int p = 0; p < 8; p++) s[p] = 8'h00;
    for (int i = 0; i < NP; i++) s[cfg_prio[3*i +: 3]] += 8'(cfg_w[5*i +: 5]);
    for (int p = 0; p < 8; p++) cfg_sum[8*p +: 8] = s[p];
  endtask

  initial begin
    #160000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R11 layout: port0,1 at level 2, port2 at level 5, others level 0
    cfg_prio = '0;
    cfg_prio[2:0] = 3'd2;
    cfg_prio[5:3] = 3'd2;
    cfg_prio[8:6] = 3'd5;
    for (int i = 0; i < NP; i++) cfg_w[5*i +: 5] = 5'd1;
    cfg_w[4:0] = 5'd4;
    cfg_w[14:10] = 5'd3;
    cfg_w[19:15] = 5'd2;
    fill_sums();
    cfg_remap = 8'h00;
    drive('0, '0, '0, 1'b0, 1'b0);
    for (int i = 0; i < NP; i++) begin m_rw[i] = 8'h80; gcount[i] = 0; end
    m_prio = '0; m_w = '0; m_sum = '0; m_remap = '0; m_cnt = 0;

    repeat (3) @(negedge clk);
    check("R1 grant in reset", {31'b0, gnt_valid}, 32'd0);
    rst_n = 1'b1;
    check("R1 onehot after reset", {22'b0, gnt_onehot}, 32'd0);

    // R8: ports 0 and 2 held across the first commit edge
    drive(10'b00_0000_0101, '0, '0, 1'b1, 1'b1);
    repeat (14) cyc("R8 commit order");

    // R3 R11: port2 at level 5 beats all others; R6 levels 2 and 0 untouched
    drive(10'b00_0000_1111, '0, '0, 1'b1, 1'b1);
    for (int i = 0; i < NP; i++) gcount[i] = 0;
    repeat (6) cyc("R3 R11 absolute priority");
    check("R3 port2 slots", gcount[2], 6);

    // R7 drain then R5 R4 share at level 2
    drive('0, '0, '0, 1'b1, 1'b1);
    cyc("R7 drain reload");
    drive(10'b00_0000_0011, '0, '0, 1'b1, 1'b1);
    for (int i = 0; i < NP; i++) gcount[i] = 0;
    repeat (50) cyc("R4 R5 weighted share");
    check("R5 port0 share", gcount[0], 40);
    check("R5 port1 share", gcount[1], 10);

    // R7: port1 empties for one cycle while port0 keeps competing
    drive(10'b00_0000_0001, '0, '0, 1'b1, 1'b1);
    cyc("R7 partial drain");
    drive(10'b00_0000_0011, '0, '0, 1'b1, 1'b1);
    repeat (6) cyc("R6 R7 resumed");

    // R2: write without data, read without space
    drive(10'b00_0000_0011, 10'b00_0000_0001, '0, 1'b0, 1'b1);
    repeat (3) cyc("R2 not eligible");
    drive(10'b00_0000_0011, 10'b00_0000_0001, 10'b00_0000_0001, 1'b0, 1'b1);
    repeat (3) cyc("R2 write data ready");

    // R10: stalled downstream
    drive(10'b00_0000_0111, '0, '0, 1'b1, 1'b0);
    repeat (3) cyc("R10 stalled");

    // R9: promote level 0
    cfg_remap = 8'h01;
    drive('0, '0, '0, 1'b1, 1'b1);
    repeat (11) cyc("R8 idle to commit");
    drive(10'b00_0001_1100, '0, '0, 1'b1, 1'b1);
    for (int i = 0; i < NP; i++) gcount[i] = 0;
    repeat (6) cyc("R9 promoted level");
    check("R9 port2 held off", gcount[2], 0);
    cfg_remap = 8'h00;

    // mixed traffic with periodic reprogramming
    for (int k = 0; k < 400; k++) begin
      if (k % 37 == 0) begin
        for (int i = 0; i < NP; i++) begin
          cfg_prio[3*i +: 3] = 3'($urandom_range(0, 3));
          cfg_w[5*i +: 5] = 5'($urandom_range(0, 31));
        end
        fill_sums();
        cfg_remap = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 15)) : 8'h00;
      end
      drive(10'($urandom()), 10'($urandom()), 10'($urandom()),
            1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0));
      cyc("R4 R10 mixed traffic");
    end

    drive('0, '0, '0, 1'b0, 1'b0);
    cyc("R10 final idle");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule